// File: doc/BRIEF.md
# Dual-Space I2C Target Front End

This block is the bus-facing half of an I2C target that exposes two separate address spaces behind one pair of open-drain wires. The first seven bits after a START carry a device identifier, and its top nibble selects the space. `1010111` opens a 512-entry data array and `1101111` opens a 64-entry clock/control register file. The byte is acknowledged only if the identifier is one of these two. The eighth bit gives the direction. A write transfer carries a two-byte word address and then any number of data bytes. A read transfer returns bytes from an internal pointer, either where the last access left it or where a preceding dummy write placed it.

SCL and SDA are sampled by a fast system clock through a synchronizer. The block never drives a high level: it only asserts `sda_oe` to pull SDA low. Storage sits outside the block behind a plain synchronous port. That port carries a space bit, an address, a one-cycle write strobe with data, and read data that is registered one clock after the address. A random read is refused when the identifier of its dummy-write phase differs from the identifier after the repeated START. This stops a read from silently crossing into the other space.

Top module: `i2c_dual_target`

## Requirements
- R1: The target acknowledges a slave byte only when its upper seven bits equal `1010111` (array, `mem_space`=0) or `1101111` (registers, `mem_space`=1). After any other identifier, SDA stays released and `mem_we` stays low until the next START or STOP.
- R2: Bit 0 of the slave byte selects the direction: 1 is a read (the target sends data) and 0 is a write (the target receives a word address and data).
- R3: In a write, the first byte after the slave byte supplies address bit 8 from its bit 0, and its other bits are ignored. The second byte supplies address bits 7..0. Both bytes are acknowledged.
- R4: Each write data byte drives `mem_we` high for exactly one clock, on the eighth SCL rising edge of that byte, with `mem_space`, `mem_addr` and `mem_wdata` valid. The byte is then acknowledged.
- R5: The pointer advances by one after every byte written or sent. It wraps from 511 to 0 in the array and from 63 to 0 in the registers, and register accesses use only its low six bits.
- R6: After reset the pointer is 0 and SDA is released, so a read with no address phase returns array entry 0.
- R7: A read byte is sent MSB first over eight SCL clocks, and then SDA is released for the master's acknowledge. On ACK the next entry follows. On NACK the target drives nothing until a START or STOP.
- R8: When a read slave byte follows a repeated START and a write address phase in the same transfer, the two identifiers must match, or the read slave byte is not acknowledged and the target stays silent.
- R9: A START, detected as SDA falling while SCL is high, restarts slave-byte reception from any state, including after a rejected identifier.
- R10: A STOP, detected as SDA rising while SCL is high, returns the target to idle and cancels a pending dummy write, so a later read in either space is accepted.
- R11: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sensed level of the SCL wire |
| sda_i | input | 1 | Sensed level of the SDA wire |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| mem_space | output | 1 | 0 selects the data array, 1 the registers |
| mem_addr | output | 9 | Entry address within the selected space |
| mem_we | output | 1 | One-cycle write strobe |
| mem_wdata | output | 8 | Byte to store when `mem_we` is high |
| mem_rdata | input | 8 | Entry at `mem_addr`, registered one clock after the address |

## Verification
A corrupted state or phase register shows up within one byte time. It appears as a missing or misplaced acknowledge bit, or as `sda_oe` toggling while SCL is high. A wrong pointer stays hidden until the next data byte. At that point it shows either as a store to the wrong model entry on the eighth SCL edge or as a read byte that differs from the model. For that reason, the directed scenarios cross both wrap points and read back right after writing. A stale dummy-write flag is visible only on the next read slave byte, so the STOP-then-read and mismatch cases each end with an acknowledge check on that byte.

// File: rtl/i2c_dt_pkg.sv
package i2c_dt_pkg;

  localparam int unsigned BYTE_W = 8;

  // space-kind nibble and fixed select bits of the 7-bit identifier
  localparam logic [3:0] ARR_KIND = 4'b1010;
  localparam logic [3:0] REG_KIND = 4'b1101;
  localparam logic [2:0] DEV_SEL  = 3'b111;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_IGNORE
  } tgt_state_e;

  typedef enum logic [1:0] {
    PH_DEV,
    PH_WA_HI,
    PH_WA_LO,
    PH_WDATA
  } rx_phase_e;

endpackage

// File: rtl/i2c_dt_rstsync.sv
module i2c_dt_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_raw,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_raw) begin
    if (!rst_n_raw) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/i2c_dt_busmon.sv
module i2c_dt_busmon #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic scl_hi,
  output logic sda_hi,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  // synchronizer stages plus one history stage for edge detection
  localparam int unsigned CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] scl_pipe_q;
  logic [CHAIN-1:0] sda_pipe_q;
  logic             scl_prev;
  logic             sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
    end else begin
      scl_pipe_q <= {scl_pipe_q[CHAIN-2:0], scl_raw};
      sda_pipe_q <= {sda_pipe_q[CHAIN-2:0], sda_raw};
    end
  end

  assign scl_hi   = scl_pipe_q[CHAIN-2];
  assign sda_hi   = sda_pipe_q[CHAIN-2];
  assign scl_prev = scl_pipe_q[CHAIN-1];
  assign sda_prev = sda_pipe_q[CHAIN-1];

  always_comb begin
    scl_rise  = scl_hi & ~scl_prev;
    scl_fall  = ~scl_hi & scl_prev;
    start_det = scl_hi & scl_prev & sda_prev & ~sda_hi;
    stop_det  = scl_hi & scl_prev & ~sda_prev & sda_hi;
  end

endmodule

// File: rtl/i2c_dt_ptr.sv
module i2c_dt_ptr #(
  parameter int unsigned ARR_AW = 9,
  parameter int unsigned REG_AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ARR_AW-1:0] load_val,
  input  logic              inc,
  input  logic              reg_space,
  output logic [ARR_AW-1:0] addr
);

  localparam logic [ARR_AW-1:0] ARR_MASK = '1;
  localparam logic [ARR_AW-1:0] REG_MASK = {{(ARR_AW-REG_AW){1'b0}}, {REG_AW{1'b1}}};

  logic [ARR_AW-1:0] ptr_q;
  logic [ARR_AW-1:0] ptr_d;
  logic [ARR_AW-1:0] mask;

  always_comb begin
    mask = reg_space ? REG_MASK : ARR_MASK;
  end

  always_comb begin
    ptr_d = ptr_q;
    if (load) begin
      ptr_d = load_val;
    end else if (inc) begin
      ptr_d = (ptr_q + 1'b1) & mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (load || inc) begin
      ptr_q <= ptr_d;
    end
  end

  assign addr = ptr_q & mask;

endmodule

// File: rtl/i2c_dual_target.sv
module i2c_dual_target
  import i2c_dt_pkg::*;
#(
  parameter int unsigned ARR_AW      = 9,
  parameter int unsigned REG_AW      = 6,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic              mem_space,
  output logic [ARR_AW-1:0] mem_addr,
  output logic              mem_we,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata
);

  localparam int unsigned       BIT_W = $clog2(BYTE_W + 1);
  localparam int unsigned       HI_W  = ARR_AW - BYTE_W;
  localparam logic [BIT_W-1:0]  FULL  = BIT_W'(BYTE_W);
  localparam logic [BIT_W-1:0]  LAST  = BIT_W'(BYTE_W - 1);

  logic rst_sync_n;
  logic scl_hi, sda_hi, scl_rise, scl_fall, start_det, stop_det;

  tgt_state_e        state_q, state_d;
  rx_phase_e         phase_q, phase_d;
  logic [BIT_W-1:0]  bitcnt_q, bitcnt_d;
  logic [BYTE_W-1:0] shreg_q, shreg_d;
  logic              space_q, space_d;
  logic              rw_q, rw_d;
  logic              pend_q, pend_d;
  logic [6:0]        pend_id_q, pend_id_d;
  logic [HI_W-1:0]   hi_q, hi_d;

  logic              ptr_load, ptr_inc;
  logic [ARR_AW-1:0] ptr_val;
  logic [6:0]        rx_id;
  logic              rx_rw, id_known, id_is_reg, pend_ok;

  i2c_dt_rstsync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n_raw  (rst_n),
    .rst_n_sync (rst_sync_n)
  );

  i2c_dt_busmon #(.SYNC_STAGES(SYNC_STAGES)) u_bus (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .scl_raw   (scl_i),
    .sda_raw   (sda_i),
    .scl_hi    (scl_hi),
    .sda_hi    (sda_hi),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_dt_ptr #(.ARR_AW(ARR_AW), .REG_AW(REG_AW)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load      (ptr_load),
    .load_val  (ptr_val),
    .inc       (ptr_inc),
    .reg_space (space_q),
    .addr      (mem_addr)
  );

  // decode of a completed slave byte
  always_comb begin
    rx_id     = shreg_q[BYTE_W-1:1];
    rx_rw     = shreg_q[0];
    id_known  = ((rx_id[6:3] == ARR_KIND) || (rx_id[6:3] == REG_KIND)) && (rx_id[2:0] == DEV_SEL);
    id_is_reg = (rx_id[6:3] == REG_KIND);
    pend_ok   = !(rx_rw && pend_q && (rx_id != pend_id_q));
  end

  // memory write strobe on the last data bit of a write byte
  always_comb begin
    mem_we    = (state_q == ST_RX) && (phase_q == PH_WDATA) && scl_rise && (bitcnt_q == LAST);
    mem_wdata = {shreg_q[BYTE_W-2:0], sda_hi};
    mem_space = space_q;
    ptr_val   = {hi_q, shreg_q};
  end

  always_comb begin
    unique case (state_q)
      ST_RX_ACK: sda_oe = 1'b1;
      ST_TX:     sda_oe = ~shreg_q[BYTE_W-1];
      default:   sda_oe = 1'b0;
    endcase
  end

  // next-state logic
  always_comb begin
    state_d   = state_q;
    phase_d   = phase_q;
    bitcnt_d  = bitcnt_q;
    shreg_d   = shreg_q;
    space_d   = space_q;
    rw_d      = rw_q;
    pend_d    = pend_q;
    pend_id_d = pend_id_q;
    hi_d      = hi_q;
    ptr_load  = 1'b0;
    ptr_inc   = 1'b0;

    if (start_det) begin
      state_d  = ST_RX;
      phase_d  = PH_DEV;
      bitcnt_d = '0;
    end else if (stop_det) begin
      state_d = ST_IDLE;
      pend_d  = 1'b0;
    end else begin
      case (state_q)
        ST_RX: begin
          if (scl_rise && (bitcnt_q != FULL)) begin
            shreg_d  = {shreg_q[BYTE_W-2:0], sda_hi};
            bitcnt_d = bitcnt_q + 1'b1;
            ptr_inc  = mem_we;
          end else if (scl_fall && (bitcnt_q == FULL)) begin
            bitcnt_d = '0;
            state_d  = ST_RX_ACK;
            case (phase_q)
              PH_DEV: begin
                if (id_known && pend_ok) begin
                  space_d = id_is_reg;
                  rw_d    = rx_rw;
                  pend_d  = 1'b0;
                  if (!rx_rw) begin
                    pend_id_d = rx_id;
                  end
                end else begin
                  state_d = ST_IGNORE;
                end
              end
              PH_WA_HI: hi_d = shreg_q[HI_W-1:0];
              PH_WA_LO: begin
                ptr_load = 1'b1;
                pend_d   = 1'b1;
              end
              default: ;
            endcase
          end
        end

        ST_RX_ACK: begin
          if (scl_fall) begin
            if ((phase_q == PH_DEV) && rw_q) begin
              state_d = ST_TX;
              shreg_d = mem_rdata;
              ptr_inc = 1'b1;
            end else begin
              state_d = ST_RX;
              case (phase_q)
                PH_DEV:   phase_d = PH_WA_HI;
                PH_WA_HI: phase_d = PH_WA_LO;
                default:  phase_d = PH_WDATA;
              endcase
            end
          end
        end

        ST_TX: begin
          if (scl_rise && (bitcnt_q != FULL)) begin
            bitcnt_d = bitcnt_q + 1'b1;
          end else if (scl_fall) begin
            if (bitcnt_q == FULL) begin
              state_d  = ST_TX_ACK;
              bitcnt_d = '0;
            end else begin
              shreg_d = {shreg_q[BYTE_W-2:0], 1'b0};
            end
          end
        end

        ST_TX_ACK: begin
          if (scl_rise) begin
            if (sda_hi) begin
              state_d = ST_IGNORE;
            end else begin
              bitcnt_d = BIT_W'(1);
            end
          end else if (scl_fall && (bitcnt_q != '0)) begin
            state_d  = ST_TX;
            bitcnt_d = '0;
            shreg_d  = mem_rdata;
            ptr_inc  = 1'b1;
          end
        end

        default: ;
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q   <= ST_IDLE;
      phase_q   <= PH_DEV;
      bitcnt_q  <= '0;
      shreg_q   <= '0;
      space_q   <= 1'b0;
      rw_q      <= 1'b0;
      pend_q    <= 1'b0;
      pend_id_q <= '0;
      hi_q      <= '0;
    end else begin
      state_q   <= state_d;
      phase_q   <= phase_d;
      bitcnt_q  <= bitcnt_d;
      shreg_q   <= shreg_d;
      space_q   <= space_d;
      rw_q      <= rw_d;
      pend_q    <= pend_d;
      pend_id_q <= pend_id_d;
      hi_q      <= hi_d;
    end
  end

endmodule

// File: rtl/i2c_dual_target_chk.sv
module i2c_dual_target_chk
  import i2c_dt_pkg::*;
#(
  parameter int unsigned ARR_AW = 9,
  parameter int unsigned REG_AW = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_hi,
  input logic              start_det,
  input logic              stop_det,
  input tgt_state_e        state,
  input logic [3:0]        bitcnt,
  input logic              sda_oe,
  input logic              mem_we,
  input logic              mem_space,
  input logic [ARR_AW-1:0] mem_addr
);

  localparam logic [ARR_AW-1:0] ARR_MASK = '1;
  localparam logic [ARR_AW-1:0] REG_MASK = {{(ARR_AW-REG_AW){1'b0}}, {REG_AW{1'b1}}};

  logic [ARR_AW-1:0] step_exp;

  always_comb begin
    step_exp = (mem_addr + 1'b1) & (mem_space ? REG_MASK : ARR_MASK);
  end

  // R4
  we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  // R5
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (mem_addr == $past(step_exp)));

  // R11
  oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_hi && $past(scl_hi)) |-> $stable(sda_oe));

  // R10
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> ((state == ST_IDLE) && !sda_oe));

  // R9
  start_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> ((state == ST_RX) && (bitcnt == 4'd0)));

endmodule

bind i2c_dual_target i2c_dual_target_chk #(
  .ARR_AW (ARR_AW),
  .REG_AW (REG_AW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .scl_hi    (scl_hi),
  .start_det (start_det),
  .stop_det  (stop_det),
  .state     (state_q),
  .bitcnt    (bitcnt_q),
  .sda_oe    (sda_oe),
  .mem_we    (mem_we),
  .mem_space (mem_space),
  .mem_addr  (mem_addr)
);

// File: tb/i2c_dual_target_tb.sv
module i2c_dual_target_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 12;
  localparam int QTR        = 4;
  localparam int ARR_N      = 512;
  localparam int REG_N      = 64;

  logic       clk;
  logic       rst_n;
  logic       m_scl;
  logic       m_sda;
  logic       sda_oe;
  logic       mem_space;
  logic [8:0] mem_addr;
  logic       mem_we;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata;
  logic       sda_bus;

  int n_checks = 0;
  int n_fail   = 0;
  int we_cnt   = 0;
  int oe_viol  = 0;
  bit done     = 0;

  logic [7:0] arr_m [ARR_N];
  logic [7:0] reg_m [REG_N];

  assign sda_bus = m_sda & ~sda_oe;

  i2c_dual_target u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (m_scl),
    .sda_i     (sda_bus),
    .sda_oe    (sda_oe),
    .mem_space (mem_space),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
  );

  function automatic logic [7:0] pat_arr(input int i);
    return 8'((i * 37) + 11);
  endfunction

  function automatic logic [7:0] pat_reg(input int i);
    return 8'((i * 5) + 144);
  endfunction

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // storage model with a registered read port
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ARR_N; i++) arr_m[i] <= pat_arr(i);
      for (int i = 0; i < REG_N; i++) reg_m[i] <= pat_reg(i);
    end else if (mem_we) begin
      if (mem_space) reg_m[mem_addr[5:0]] <= mem_wdata;
      else           arr_m[mem_addr]      <= mem_wdata;
    end
    mem_rdata <= mem_space ? reg_m[mem_addr[5:0]] : arr_m[mem_addr];
  end

  // port monitors: write strobes and SDA changes while SCL high (R11)
  logic prev_scl, prev_oe;
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we) we_cnt++;
      if (m_scl && prev_scl && (sda_oe !== prev_oe)) oe_viol++;
    end
    prev_scl = m_scl;
    prev_oe  = sda_oe;
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_bit(input logic drv, output logic seen);
    wait_clk(QTR);
    m_sda = drv;
    wait_clk(HALF);
    m_scl = 1'b1;
    wait_clk(HALF / 2);
    seen = sda_bus;
    wait_clk(HALF / 2);
    m_scl = 1'b0;
  endtask

  task automatic bus_start;
    m_sda = 1'b1; m_scl = 1'b1; wait_clk(HALF);
    m_sda = 1'b0; wait_clk(HALF);
    m_scl = 1'b0;
  endtask

  task automatic bus_rstart;
    wait_clk(QTR);
    m_sda = 1'b1; wait_clk(HALF);
    m_scl = 1'b1; wait_clk(HALF);
    m_sda = 1'b0; wait_clk(HALF);
    m_scl = 1'b0;
  endtask

  task automatic bus_stop;
    wait_clk(QTR);
    m_sda = 1'b0; wait_clk(HALF);
    m_scl = 1'b1; wait_clk(HALF);
    m_sda = 1'b1; wait_clk(HALF);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    acked = ~s;
  endtask

  task automatic get_byte(input logic give_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      b[i] = s;
    end
    clk_bit(~give_ack, s);
  endtask

  task automatic t_reset;
    check("R6 sda released after reset", 16'(sda_oe), 16'd0);
    check("R6 pointer zero after reset", 16'(mem_addr), 16'd0);
    check("R4 no strobe after reset", 16'(mem_we), 16'd0);
  endtask

  task automatic t_current_read_at_reset;
    logic a; logic [7:0] b;
    bus_start;
    send_byte(8'hAF, a);
    check("R1 array read id acked", 16'(a), 16'd1);
    get_byte(1'b0, b);
    check("R6 current read returns array entry 0", 16'(b), 16'(pat_arr(0)));
    bus_stop;
  endtask

  task automatic t_array_write_wrap;
    logic a; int w0;
    w0 = we_cnt;
    bus_start;
    send_byte(8'hAE, a); check("R2 write id acked", 16'(a), 16'd1);
    send_byte(8'hF1, a); check("R3 high address byte acked", 16'(a), 16'd1);
    send_byte(8'hFE, a); check("R3 low address byte acked", 16'(a), 16'd1);
    send_byte(8'h11, a); check("R4 data byte acked", 16'(a), 16'd1);
    send_byte(8'h22, a);
    send_byte(8'h33, a);
    bus_stop;
    check("R3 A8 from bit 0, upper bits ignored", 16'(arr_m[9'h1FE]), 16'h0011);
    check("R5 second byte at next entry", 16'(arr_m[9'h1FF]), 16'h0022);
    check("R5 array wraps 511 to 0", 16'(arr_m[0]), 16'h0033);
    check("R4 one strobe per data byte", 16'(we_cnt - w0), 16'd3);
  endtask

  task automatic t_random_read_seq;
    logic a; logic [7:0] b;
    bus_start;
    send_byte(8'hAE, a); send_byte(8'h00, a); send_byte(8'h10, a);
    bus_rstart;
    send_byte(8'hAF, a);
    check("R8 matching read id acked", 16'(a), 16'd1);
    get_byte(1'b1, b); check("R7 first sequential byte", 16'(b), 16'(pat_arr(16)));
    get_byte(1'b1, b); check("R7 second sequential byte", 16'(b), 16'(pat_arr(17)));
    get_byte(1'b0, b); check("R7 third sequential byte", 16'(b), 16'(pat_arr(18)));
    bus_stop;
  endtask

  task automatic t_reg_write_wrap;
    logic a;
    bus_start;
    send_byte(8'hDE, a); check("R1 register write id acked", 16'(a), 16'd1);
    send_byte(8'h00, a); send_byte(8'h3F, a);
    send_byte(8'hA1, a); send_byte(8'hA2, a);
    bus_stop;
    check("R5 register entry 63 written", 16'(reg_m[63]), 16'h00A1);
    check("R5 registers wrap 63 to 0", 16'(reg_m[0]), 16'h00A2);
  endtask

  task automatic t_reg_read_nack_tail;
    logic a; logic [7:0] b;
    bus_start;
    send_byte(8'hDE, a); send_byte(8'h00, a); send_byte(8'h02, a);
    bus_rstart;
    send_byte(8'hDF, a);
    check("R8 matching register read acked", 16'(a), 16'd1);
    get_byte(1'b0, b); check("R7 register byte", 16'(b), 16'(pat_reg(2)));
    get_byte(1'b1, b); check("R7 silent after NACK", 16'(b), 16'h00FF);
    bus_stop;
  endtask

  task automatic t_id_mismatch;
    logic a; logic [7:0] b;
    bus_start;
    send_byte(8'hAE, a); send_byte(8'h00, a); send_byte(8'h05, a);
    bus_rstart;
    send_byte(8'hDF, a);
    check("R8 mismatched read id refused", 16'(a), 16'd0);
    get_byte(1'b1, b);
    check("R8 no data after refusal", 16'(b), 16'h00FF);
    bus_stop;
  endtask

  task automatic t_bad_id;
    logic a; int w0;
    w0 = we_cnt;
    bus_start;
    send_byte(8'hA6, a); check("R1 unknown id refused", 16'(a), 16'd0);
    send_byte(8'h55, a); check("R1 later byte not acked", 16'(a), 16'd0);
    send_byte(8'h66, a); check("R1 still silent", 16'(a), 16'd0);
    bus_stop;
    check("R1 no writes for unknown id", 16'(we_cnt - w0), 16'd0);
  endtask

  task automatic t_restart_recovers;
    logic a; logic [7:0] b;
    bus_start;
    send_byte(8'h12, a); check("R1 foreign id refused", 16'(a), 16'd0);
    bus_rstart;
    send_byte(8'hAE, a); check("R9 repeated START after refusal acked", 16'(a), 16'd1);
    send_byte(8'h00, a); send_byte(8'h30, a); send_byte(8'h77, a);
    bus_stop;
    check("R9 write after repeated START stored", 16'(arr_m[9'h030]), 16'h0077);
    bus_start;
    send_byte(8'hAF, a);
    get_byte(1'b0, b);
    check("R5 current read follows last write", 16'(b), 16'(pat_arr(49)));
    check("R2 read bit gives data out", 16'(a), 16'd1);
    bus_stop;
  endtask

  task automatic t_stop_clears;
    logic a; logic [7:0] b;
    bus_start;
    send_byte(8'hAE, a); send_byte(8'h00, a); send_byte(8'h40, a);
    bus_stop;
    bus_start;
    send_byte(8'hDF, a);
    check("R10 STOP cancels pending dummy write", 16'(a), 16'd1);
    get_byte(1'b0, b);
    check("R10 register read at masked pointer", 16'(b), 16'h00A2);
    bus_stop;
  endtask

  task automatic t_oe_timing;
    check("R11 SDA drive changes only with SCL low", 16'(oe_viol), 16'd0);
  endtask

  initial begin
    rst_n = 1'b0;
    m_scl = 1'b1;
    m_sda = 1'b1;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset;
    t_current_read_at_reset;
    t_array_write_wrap;
    t_random_read_seq;
    t_reg_write_wrap;
    t_reg_read_nack_tail;
    t_id_mismatch;
    t_bad_id;
    t_restart_recovers;
    t_stop_clears;
    t_oe_timing;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog all requirements actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule